// File: doc/BRIEF.md
# Receive Ring Writer

This block takes an arriving packet stream and files it into two circular buffers in memory: a header ring, which receives one 64-bit descriptor per packet, and a payload ring, which receives one 32-bit word per payload beat. Each ring holds a power-of-two number of entries and sits at a base address aligned to its size in bytes. The block owns the two write cursors. Software supplies the two read cursors, and the block compares against them before it writes anything, so unread entries are never overwritten.

The block applies no backpressure. When the payload ring is full, it drops the rest of the current packet's payload, leaves a stall marker in the header ring, and starts again with the next packet. When the header ring is full, it drops headers but keeps delivering payload while the payload ring has room. It counts the lost headers and reports that count in the next header it manages to store.

Two background activities run alongside the writes. At a programmable interval, the block writes both free-running cursors to a fixed report address. When the header ring is left partway through a write unit for a programmable number of idle cycles, the block fills the rest of the unit with no-op entries.

Top module: `rxr_ring_writer`

## Requirements
- R1: A header entry at cursor c is written to byte address HDR_BASE + 8*(c mod HDR_SIZE). A payload word at cursor p is written to PAY_BASE + 4*(p mod PAY_SIZE). Both bases are multiples of their ring's size in bytes.
- R2: Both write cursors are free-running 32-bit counters that start at zero and advance by exactly one for each entry written to their ring. They continue past the ring size and wrap only at 2^32.
- R3: Used space is computed as (write cursor − read cursor) with 32-bit wraparound. No entry is written to a ring while its used space is at least its size.
- R4: A payload beat that meets a full payload ring is dropped. In that same cycle, a stall marker is written to the header ring with type 2, length 0 and the current payload cursor. If the header ring is also full, the marker is counted as an omitted header instead. Every later beat is dropped until the next header arrives. From that header on, the next packet is handled normally.
- R5: A header that meets a full header ring is dropped, and an omitted-header counter increments, saturating at 4095. The next packet header that is stored gets type 1 and carries the count in bits [63:52]. The counter is cleared at that point.
- R6: While headers are being dropped, payload beats are still written whenever the payload ring has room.
- R7: A header entry has type in [3:0] (0 normal, 1 with omitted count, 2 stall marker, 3 no-op), length in [19:4], and the payload cursor at the time of writing in [51:20]. For a packet header, the length is the packet's length; for all other types it is 0. For a type 1 entry, bits [63:52] hold the omitted-header count; for all other types they are 0.
- R8: When the report interval N is nonzero, a report write of {payload cursor, header cursor} (payload cursor in [63:32]) goes to RPT_ADDR every N cycles. The reported cursors exclude writes that appear in the same cycle as the report. N = 0 disables reporting.
- R9: When the idle timeout T is nonzero and the header cursor is not a multiple of 2^UNIT_LOG2, no-op entries are written after T cycles without a header write, one per cycle, until the cursor is aligned. No no-op entry is written while payload is stalled.
- R10: Each ring write appears on the outputs in the cycle after the input that caused it. After reset, no write strobe is active and both cursors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdrValid | input | 1 | A packet header is present; starts a packet |
| hdrLen | input | 16 | Payload length of the arriving packet, in beats |
| beatValid | input | 1 | A payload beat is present (never together with hdrValid) |
| beatData | input | 32 | Payload beat contents |
| hdrRdCursor | input | 32 | Software read cursor of the header ring |
| payRdCursor | input | 32 | Software read cursor of the payload ring |
| reportInterval | input | 16 | Cycles between cursor reports; 0 disables reporting |
| idleTimeout | input | 16 | Idle cycles before no-op padding starts; 0 disables padding |
| hdrWrEn | output | 1 | Header ring write strobe |
| hdrWrAddr | output | 32 | Header ring write byte address |
| hdrWrData | output | 64 | Header entry |
| payWrEn | output | 1 | Payload ring write strobe |
| payWrAddr | output | 32 | Payload ring write byte address |
| payWrData | output | 32 | Payload word |
| rptWrEn | output | 1 | Cursor report write strobe |
| rptWrAddr | output | 32 | Cursor report byte address |
| rptWrData | output | 64 | {payload cursor, header cursor} |

## Verification
Several properties are checked on every cycle:
- No write is issued while its ring is full.
- Every write address falls inside its ring and matches the cursor slot just consumed.
- Payload writes stay blocked while a stall is in force.
- No-op entries appear only on a misaligned cursor outside a stall.
- The omitted-header counter only climbs by one or clears, and it is zero right after it has been reported.

Other behaviours can only be shown by the bench's scenarios:
- the exact contents and order of entries,
- resumption at the next packet after a payload overrun,
- payload delivery while headers are being dropped,
- saturation of the omitted count,
- the spacing and contents of cursor reports,
- the exact delay before padding.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;

  typedef enum logic [3:0] {
    ENT_NORMAL = 4'd0,
    ENT_OMIT   = 4'd1,
    ENT_STALL  = 4'd2,
    ENT_NOOP   = 4'd3
  } entKind_t;

  typedef struct packed {
    logic     hdrWrite;
    entKind_t hdrKind;
    logic     payWrite;
    logic     omitInc;
    logic     omitClear;
    logic     rptFire;
  } ctlStb_t;

  localparam int OMIT_W = 12;

endpackage

// File: rtl/rxr_ctrl.sv
`timescale 1ns/1ps
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdrValid,
  input  logic             beatValid,
  input  logic [CFG_W-1:0] reportInterval,
  input  logic [CFG_W-1:0] idleTimeout,
  input  logic             hdrFull,
  input  logic             payFull,
  input  logic             hdrAligned,
  input  logic             hdrNextAligned,
  input  logic             omitPending,
  output ctlStb_t          stb
);

  localparam logic [CFG_W:0] ONE_X = {{CFG_W{1'b0}}, 1'b1};

  logic             payStalled;
  logic             padActive;
  logic [CFG_W-1:0] idleCnt;
  logic [CFG_W-1:0] rptCnt;
  logic             stallStart;
  logic             idleExpire;
  logic             noopFire;
  logic [CFG_W:0]   idleNext;
  logic [CFG_W:0]   rptNext;

  assign idleNext   = {1'b0, idleCnt} + ONE_X;
  assign rptNext    = {1'b0, rptCnt} + ONE_X;
  assign idleExpire = (idleTimeout != '0) && (idleNext >= {1'b0, idleTimeout});

  // Decision for this cycle: packet header, payload beat, then padding.
  always_comb begin
    stb        = '0;
    stb.hdrKind = ENT_NORMAL;
    stallStart = 1'b0;
    noopFire   = 1'b0;
    if (hdrValid) begin
      if (hdrFull) begin
        stb.omitInc = 1'b1;
      end else begin
        stb.hdrWrite  = 1'b1;
        stb.hdrKind   = omitPending ? ENT_OMIT : ENT_NORMAL;
        stb.omitClear = omitPending;
      end
    end else if (beatValid && !payStalled) begin
      if (payFull) begin
        stallStart = 1'b1;
        if (hdrFull) begin
          stb.omitInc = 1'b1;
        end else begin
          stb.hdrWrite = 1'b1;
          stb.hdrKind  = ENT_STALL;
        end
      end else begin
        stb.payWrite = 1'b1;
      end
    end
    if (!stb.hdrWrite && !hdrAligned && !hdrFull && !payStalled &&
        (padActive || idleExpire)) begin
      noopFire     = 1'b1;
      stb.hdrWrite = 1'b1;
      stb.hdrKind  = ENT_NOOP;
    end
    stb.rptFire = (reportInterval != '0) && (rptNext >= {1'b0, reportInterval});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      payStalled <= 1'b0;
      padActive  <= 1'b0;
      idleCnt    <= '0;
      rptCnt     <= '0;
    end else begin
      if (hdrValid)        payStalled <= 1'b0;
      else if (stallStart) payStalled <= 1'b1;

      if (stb.hdrWrite) padActive <= (padActive || noopFire) && !hdrNextAligned;
      else              padActive <= padActive && !hdrAligned;

      if (stb.hdrWrite || hdrAligned) idleCnt <= '0;
      else if (!idleExpire)           idleCnt <= idleNext[CFG_W-1:0];

      rptCnt <= stb.rptFire ? '0 : rptNext[CFG_W-1:0];
    end
  end

  AST_NO_HDR_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    stb.hdrWrite |-> !hdrFull); // R3
  AST_NO_PAY_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    stb.payWrite |-> !payFull); // R3
  AST_STALL_BLOCKS_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    payStalled |-> !stb.payWrite); // R4
  AST_NOOP_ONLY_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.hdrWrite && stb.hdrKind == ENT_NOOP) |-> (!hdrAligned && !payStalled)); // R9

endmodule

// File: rtl/rxr_dpath.sv
`timescale 1ns/1ps
module rxr_dpath
  import rxr_pkg::*;
#(
  parameter int          HDR_IDX_W = 3,
  parameter int          PAY_IDX_W = 4,
  parameter int          UNIT_LOG2 = 1,
  parameter logic [31:0] HDR_BASE  = 32'h0001_0000,
  parameter logic [31:0] PAY_BASE  = 32'h0002_0000,
  parameter logic [31:0] RPT_ADDR  = 32'h0003_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctlStb_t     stb,
  input  logic [15:0] hdrLen,
  input  logic [31:0] beatData,
  input  logic [31:0] hdrRdCursor,
  input  logic [31:0] payRdCursor,
  output logic        hdrFull,
  output logic        payFull,
  output logic        hdrAligned,
  output logic        hdrNextAligned,
  output logic        omitPending,
  output logic        hdrWrEn,
  output logic [31:0] hdrWrAddr,
  output logic [63:0] hdrWrData,
  output logic        payWrEn,
  output logic [31:0] payWrAddr,
  output logic [31:0] payWrData,
  output logic        rptWrEn,
  output logic [31:0] rptWrAddr,
  output logic [63:0] rptWrData
);

  localparam logic [31:0]       HDR_SIZE  = 32'd1 << HDR_IDX_W;
  localparam logic [31:0]       PAY_SIZE  = 32'd1 << PAY_IDX_W;
  localparam logic [31:0]       HDR_MASK  = HDR_SIZE - 32'd1;
  localparam logic [31:0]       PAY_MASK  = PAY_SIZE - 32'd1;
  localparam logic [31:0]       HDR_SPAN  = (HDR_SIZE << 3) - 32'd1;
  localparam logic [31:0]       PAY_SPAN  = (PAY_SIZE << 2) - 32'd1;
  localparam logic [31:0]       UNIT_MASK = (32'd1 << UNIT_LOG2) - 32'd1;
  localparam logic [OMIT_W-1:0] OMIT_MAX  = '1;

  logic [31:0]       hdrWrCur;
  logic [31:0]       payWrCur;
  logic [OMIT_W-1:0] omitCnt;
  logic [31:0]       hdrUsed;
  logic [31:0]       payUsed;
  logic [63:0]       entry;
  logic [15:0]       lenField;
  logic [OMIT_W-1:0] omitField;

  assign hdrUsed        = hdrWrCur - hdrRdCursor;
  assign payUsed        = payWrCur - payRdCursor;
  assign hdrFull        = hdrUsed >= HDR_SIZE;
  assign payFull        = payUsed >= PAY_SIZE;
  assign hdrAligned     = (hdrWrCur & UNIT_MASK) == '0;
  assign hdrNextAligned = ((hdrWrCur + 32'd1) & UNIT_MASK) == '0;
  assign omitPending    = omitCnt != '0;

  always_comb begin
    lenField  = (stb.hdrKind == ENT_NORMAL || stb.hdrKind == ENT_OMIT) ? hdrLen : 16'd0;
    omitField = (stb.hdrKind == ENT_OMIT) ? omitCnt : '0;
    entry     = {omitField, payWrCur, lenField, stb.hdrKind};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdrWrCur  <= '0;
      payWrCur  <= '0;
      omitCnt   <= '0;
      hdrWrEn   <= 1'b0;
      hdrWrAddr <= '0;
      hdrWrData <= '0;
      payWrEn   <= 1'b0;
      payWrAddr <= '0;
      payWrData <= '0;
      rptWrEn   <= 1'b0;
      rptWrAddr <= '0;
      rptWrData <= '0;
    end else begin
      hdrWrEn <= stb.hdrWrite;
      if (stb.hdrWrite) begin
        hdrWrAddr <= HDR_BASE | ((hdrWrCur & HDR_MASK) << 3);
        hdrWrData <= entry;
        hdrWrCur  <= hdrWrCur + 32'd1;
      end
      payWrEn <= stb.payWrite;
      if (stb.payWrite) begin
        payWrAddr <= PAY_BASE | ((payWrCur & PAY_MASK) << 2);
        payWrData <= beatData;
        payWrCur  <= payWrCur + 32'd1;
      end
      if (stb.omitClear)                        omitCnt <= '0;
      else if (stb.omitInc && omitCnt != OMIT_MAX) omitCnt <= omitCnt + 1'b1;
      rptWrEn <= stb.rptFire;
      if (stb.rptFire) begin
        rptWrAddr <= RPT_ADDR;
        rptWrData <= {payWrCur, hdrWrCur};
      end
    end
  end

  AST_HDR_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    hdrWrEn |-> ((hdrWrAddr & ~HDR_SPAN) == HDR_BASE)); // R1
  AST_PAY_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    payWrEn |-> ((payWrAddr & ~PAY_SPAN) == PAY_BASE)); // R1
  AST_HDR_SLOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hdrWrEn |-> (((hdrWrAddr >> 3) & HDR_MASK) == ((hdrWrCur - 32'd1) & HDR_MASK))); // R2
  AST_OMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (omitCnt != $past(omitCnt)) |-> (omitCnt == $past(omitCnt) + 1'b1 || omitCnt == '0)); // R5
  AST_OMIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    stb.omitClear |=> !omitPending); // R5

endmodule

// File: rtl/rxr_ring_writer.sv
`timescale 1ns/1ps
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int          HDR_IDX_W = 3,
  parameter int          PAY_IDX_W = 4,
  parameter int          UNIT_LOG2 = 1,
  parameter int          CFG_W     = 16,
  parameter logic [31:0] HDR_BASE  = 32'h0001_0000,
  parameter logic [31:0] PAY_BASE  = 32'h0002_0000,
  parameter logic [31:0] RPT_ADDR  = 32'h0003_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdrValid,
  input  logic [15:0]      hdrLen,
  input  logic             beatValid,
  input  logic [31:0]      beatData,
  input  logic [31:0]      hdrRdCursor,
  input  logic [31:0]      payRdCursor,
  input  logic [CFG_W-1:0] reportInterval,
  input  logic [CFG_W-1:0] idleTimeout,
  output logic             hdrWrEn,
  output logic [31:0]      hdrWrAddr,
  output logic [63:0]      hdrWrData,
  output logic             payWrEn,
  output logic [31:0]      payWrAddr,
  output logic [31:0]      payWrData,
  output logic             rptWrEn,
  output logic [31:0]      rptWrAddr,
  output logic [63:0]      rptWrData
);

  ctlStb_t stb;
  logic    hdrFull;
  logic    payFull;
  logic    hdrAligned;
  logic    hdrNextAligned;
  logic    omitPending;

  rxr_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .hdrValid       (hdrValid),
    .beatValid      (beatValid),
    .reportInterval (reportInterval),
    .idleTimeout    (idleTimeout),
    .hdrFull        (hdrFull),
    .payFull        (payFull),
    .hdrAligned     (hdrAligned),
    .hdrNextAligned (hdrNextAligned),
    .omitPending    (omitPending),
    .stb            (stb)
  );

  rxr_dpath #(
    .HDR_IDX_W (HDR_IDX_W),
    .PAY_IDX_W (PAY_IDX_W),
    .UNIT_LOG2 (UNIT_LOG2),
    .HDR_BASE  (HDR_BASE),
    .PAY_BASE  (PAY_BASE),
    .RPT_ADDR  (RPT_ADDR)
  ) u_dpath (
    .clk            (clk),
    .rst_n          (rst_n),
    .stb            (stb),
    .hdrLen         (hdrLen),
    .beatData       (beatData),
    .hdrRdCursor    (hdrRdCursor),
    .payRdCursor    (payRdCursor),
    .hdrFull        (hdrFull),
    .payFull        (payFull),
    .hdrAligned     (hdrAligned),
    .hdrNextAligned (hdrNextAligned),
    .omitPending    (omitPending),
    .hdrWrEn        (hdrWrEn),
    .hdrWrAddr      (hdrWrAddr),
    .hdrWrData      (hdrWrData),
    .payWrEn        (payWrEn),
    .payWrAddr      (payWrAddr),
    .payWrData      (payWrData),
    .rptWrEn        (rptWrEn),
    .rptWrAddr      (rptWrAddr),
    .rptWrData      (rptWrData)
  );

endmodule

// File: tb/rxr_ring_writer_tb.sv
`timescale 1ns/1ps
module rxr_ring_writer_tb;

  localparam int unsigned HSZ      = 8;
  localparam int unsigned PSZ      = 16;
  localparam logic [31:0] HBASE    = 32'h0001_0000;
  localparam logic [31:0] PBASE    = 32'h0002_0000;
  localparam logic [31:0] RADDR    = 32'h0003_0000;
  localparam int unsigned RPT_N    = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdrValid = 1'b0;
  logic [15:0] hdrLen = '0;
  logic        beatValid = 1'b0;
  logic [31:0] beatData = '0;
  logic [31:0] hdrRdCursor = '0;
  logic [31:0] payRdCursor = '0;
  logic [15:0] reportInterval = 16'(RPT_N);
  logic [15:0] idleTimeout = '0;
  logic        hdrWrEn;
  logic [31:0] hdrWrAddr;
  logic [63:0] hdrWrData;
  logic        payWrEn;
  logic [31:0] payWrAddr;
  logic [31:0] payWrData;
  logic        rptWrEn;
  logic [31:0] rptWrAddr;
  logic [63:0] rptWrData;

  always #2 clk = ~clk;

  rxr_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .hdrValid(hdrValid), .hdrLen(hdrLen),
    .beatValid(beatValid), .beatData(beatData), .hdrRdCursor(hdrRdCursor),
    .payRdCursor(payRdCursor), .reportInterval(reportInterval), .idleTimeout(idleTimeout),
    .hdrWrEn(hdrWrEn), .hdrWrAddr(hdrWrAddr), .hdrWrData(hdrWrData),
    .payWrEn(payWrEn), .payWrAddr(payWrAddr), .payWrData(payWrData),
    .rptWrEn(rptWrEn), .rptWrAddr(rptWrAddr), .rptWrData(rptWrData)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic [63:0] expHdr[$];
  logic [31:0] expHdrAddr[$];
  logic [31:0] expPay[$];
  logic [31:0] expPayAddr[$];

  int unsigned mHdrCur = 0;
  int unsigned mPayCur = 0;
  int unsigned mOmit   = 0;
  bit          mStalled = 0;
  int unsigned beatSeq = 0;

  int unsigned cyc = 0;
  int unsigned hdrSeen = 0;
  int unsigned paySeen = 0;
  int unsigned lastHdrCyc = 0;
  int unsigned lastRptCyc = 0;
  int unsigned gapExpect = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkEntry(input logic [3:0] kind, input logic [15:0] len,
                                          input logic [31:0] pcur, input logic [11:0] cnt);
    return {cnt, pcur, len, kind};
  endfunction

  task automatic pushHdr(input logic [63:0] e);
    expHdr.push_back(e);
    expHdrAddr.push_back(HBASE | ((mHdrCur % HSZ) << 3));
    mHdrCur++;
  endtask

  // Driver: a header cycle, modelled from R3, R5, R7
  task automatic sendHdr(input logic [15:0] len);
    hdrValid = 1'b1;
    hdrLen   = len;
    mStalled = 0;
    if (mHdrCur - hdrRdCursor >= HSZ) begin
      if (mOmit < 4095) mOmit++;
    end else begin
      pushHdr(mkEntry(mOmit != 0 ? 4'd1 : 4'd0, len, mPayCur, 12'(mOmit)));
      mOmit = 0;
    end
    @(negedge clk);
    hdrValid = 1'b0;
  endtask

  // Driver: a payload beat, modelled from R3, R4, R6
  task automatic sendBeat();
    logic [31:0] d;
    d = 32'hA500_0000 + beatSeq;
    beatSeq++;
    beatValid = 1'b1;
    beatData  = d;
    if (!mStalled) begin
      if (mPayCur - payRdCursor >= PSZ) begin
        mStalled = 1;
        if (mHdrCur - hdrRdCursor >= HSZ) begin
          if (mOmit < 4095) mOmit++;
        end else begin
          pushHdr(mkEntry(4'd2, 16'd0, mPayCur, 12'd0));
        end
      end else begin
        expPay.push_back(d);
        expPayAddr.push_back(PBASE | ((mPayCur % PSZ) << 2));
        mPayCur++;
      end
    end
    @(negedge clk);
    beatValid = 1'b0;
  endtask

  task automatic sendPkt(input int len);
    sendHdr(16'(len));
    for (int i = 0; i < len; i++) sendBeat();
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (rptWrEn) begin
        chk(rptWrAddr == RADDR, "R8", "report address", 64'(rptWrAddr), 64'(RADDR));
        chk(rptWrData == {32'(paySeen), 32'(hdrSeen)}, "R8 R2", "report cursors",
            rptWrData, {32'(paySeen), 32'(hdrSeen)});
        if (lastRptCyc != 0)
          chk(cyc - lastRptCyc == RPT_N, "R8", "report spacing", 64'(cyc - lastRptCyc), 64'(RPT_N));
        lastRptCyc = cyc;
      end
      if (hdrWrEn) begin
        if (expHdr.size() == 0) begin
          chk(1'b0, "R3", "unexpected header write", hdrWrData, 64'd0);
        end else begin
          logic [63:0] e;
          logic [31:0] a;
          e = expHdr.pop_front();
          a = expHdrAddr.pop_front();
          chk(hdrWrData == e, "R7", "header entry", hdrWrData, e);
          chk(hdrWrAddr == a, "R1", "header address", 64'(hdrWrAddr), 64'(a));
          if (e[3:0] == 4'd3 && gapExpect != 0) begin
            chk(cyc - lastHdrCyc == gapExpect, "R9", "no-op delay",
                64'(cyc - lastHdrCyc), 64'(gapExpect));
            gapExpect = 0;
          end
        end
        hdrSeen++;
        lastHdrCyc = cyc;
      end
      if (payWrEn) begin
        if (expPay.size() == 0) begin
          chk(1'b0, "R4", "unexpected payload write", 64'(payWrData), 64'd0);
        end else begin
          logic [31:0] e;
          logic [31:0] a;
          e = expPay.pop_front();
          a = expPayAddr.pop_front();
          chk(payWrData == e, "R6", "payload word", 64'(payWrData), 64'(e));
          chk(payWrAddr == a, "R1", "payload address", 64'(payWrAddr), 64'(a));
        end
        paySeen++;
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!hdrWrEn && !payWrEn && !rptWrEn, "R10", "outputs in reset",
        {61'd0, hdrWrEn, payWrEn, rptWrEn}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hdrWrEn && !payWrEn, "R10", "idle after reset", {62'd0, hdrWrEn, payWrEn}, 64'd0);

    // Normal traffic, readers keep up (R7, R1, R10)
    for (int k = 0; k < 4; k++) begin
      hdrRdCursor = mHdrCur;
      payRdCursor = mPayCur;
      sendPkt(k == 2 ? 0 : k + 2);
    end
    repeat (3) @(negedge clk);

    // Payload overrun: 20 beats into 16 free slots (R4)
    hdrRdCursor = mHdrCur;
    payRdCursor = mPayCur;
    sendPkt(20);
    repeat (2) @(negedge clk);
    payRdCursor = mPayCur;
    hdrRdCursor = mHdrCur;
    sendPkt(3); // R4 resumes at next packet
    repeat (3) @(negedge clk);

    // Header overrun while payload keeps flowing (R5, R6)
    hdrRdCursor = mHdrCur;
    for (int k = 0; k < 10; k++) begin
      payRdCursor = mPayCur;
      sendPkt(1);
    end
    repeat (2) @(negedge clk);
    hdrRdCursor = mHdrCur;
    payRdCursor = mPayCur;
    sendPkt(2); // carries omitted count 2
    sendPkt(1); // count cleared: normal type
    repeat (3) @(negedge clk);

    // Saturation of omitted count (R5)
    hdrRdCursor = mHdrCur - HSZ;
    for (int k = 0; k < 4100; k++) sendHdr(16'd0);
    chk(mOmit == 4095, "R5", "model saturation", 64'(mOmit), 64'd4095);
    hdrRdCursor = mHdrCur;
    sendHdr(16'd5);
    repeat (3) @(negedge clk);

    // No-op padding (R9)
    hdrRdCursor = mHdrCur;
    payRdCursor = mPayCur;
    if ((mHdrCur % 2) == 1) pushHdr(mkEntry(4'd3, 16'd0, mPayCur, 12'd0));
    idleTimeout = 16'd4;
    repeat (8) @(negedge clk);
    hdrRdCursor = mHdrCur;
    sendPkt(2);
    gapExpect = 4;
    pushHdr(mkEntry(4'd3, 16'd0, mPayCur, 12'd0));
    repeat (10) @(negedge clk);
    chk(gapExpect == 0, "R9", "no-op observed", 64'(gapExpect), 64'd0);
    idleTimeout = 16'd0;

    repeat (20) @(negedge clk);
    chk(expHdr.size() == 0, "R2", "header entries all written", 64'(expHdr.size()), 64'd0);
    chk(expPay.size() == 0, "R6", "payload words all written", 64'(expPay.size()), 64'd0);
    chk(hdrSeen == mHdrCur, "R2", "header cursor count", 64'(hdrSeen), 64'(mHdrCur));
    chk(paySeen > PSZ, "R2", "payload cursor passed ring size", 64'(paySeen), 64'(PSZ + 1));
    finishRun();
  end

endmodule